// File: doc/BRIEF.md
# Programmable acquisition window timer

This block measures out the interval during which a sample-and-hold circuit tracks its input before a conversion starts. A start pulse opens the window. The window length is a fixed base count chosen by the conversion mode, plus twice a 4-bit extension value taken from the instruction being run. The block raises an acquire-active level for the whole window. It then gives a single-cycle done pulse, which the conversion engine uses as its cue to begin.

The mode select picks between two bases. A high-resolution conversion uses a base of 9 cycles. A low-resolution conversion or a limit comparison uses a base of 2 cycles. Both the mode and the extension are captured when the window opens, so the instruction word may change freely while the window is running. The block counts clock cycles only and has no knowledge of the analog path.

Top module: `acq_window_timer`

## Requirements
- R1: With mode_hi_i = 1 at start, acq_active_o stays high for exactly 9 + 2·D cycles, where D is acq_ext_i.
- R2: With mode_hi_i = 0 at start, acq_active_o stays high for exactly 2 + 2·D cycles.
- R3: acq_ext_i is an unsigned value from 0 to 15. D = 0 gives the bare base window, and D = 15 gives 39 cycles (high resolution) or 32 cycles (low resolution).
- R4: acq_active_o rises on the cycle after a start that is accepted, and never rises without a start in the cycle before.
- R5: done_o is high for exactly one cycle, the first cycle after acq_active_o falls.
- R6: The mode and D are captured when a start is accepted. Changes to mode_hi_i or acq_ext_i during the window do not change its length.
- R7: A start that arrives while acq_active_o is high is ignored, and the window in progress keeps its original length.
- R8: While rst_ni is low, acq_active_o and done_o are low. A reset asserted during a window ends it, and no done pulse follows.
- R9: A start that arrives in the done cycle is accepted and opens a new window on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to open an acquisition window |
| mode_hi_i | input | 1 | 1 = high-resolution base of 9 cycles; 0 = low-resolution or limit-comparison base of 2 cycles |
| acq_ext_i | input | 4 | Extension value D, in units of two cycles |
| acq_active_o | output | 1 | High for the whole acquisition window |
| done_o | output | 1 | One-cycle pulse when the window ends |

## Verification
The hardest cases to reach are the ones where a second request arrives at the edges of a window. A start on the last active cycle must be dropped. A start in the done cycle must be honoured. The stimulus drives random starts on random active cycles, including the final one, and runs directed back-to-back windows that start exactly in the done cycle. While each window runs, the stimulus also rewrites the mode and extension inputs, so that a failure to capture them shows up as a wrong window length.

// File: rtl/acq_window_pkg.sv
package acq_window_pkg;
  parameter int unsigned ACQ_EXT_W   = 4;
  parameter int unsigned ACQ_HI_BASE = 9;
  parameter int unsigned ACQ_LO_BASE = 2;
  localparam int unsigned ACQ_MAX_LEN =
    ((ACQ_HI_BASE > ACQ_LO_BASE) ? ACQ_HI_BASE : ACQ_LO_BASE) + 2 * ((1 << ACQ_EXT_W) - 1);
  localparam int unsigned ACQ_CNT_W = $clog2(ACQ_MAX_LEN + 1);

  typedef enum logic {
    ACQ_MODE_LO = 1'b0,
    ACQ_MODE_HI = 1'b1
  } acq_mode_e;
endpackage

// File: rtl/acq_len_calc.sv
module acq_len_calc #(
  parameter int unsigned EXT_W   = 4,
  parameter int unsigned CNT_W   = 6,
  parameter int unsigned HI_BASE = 9,
  parameter int unsigned LO_BASE = 2
) (
  input  acq_window_pkg::acq_mode_e mode_i,
  input  logic [EXT_W-1:0]          ext_i,
  output logic [CNT_W-1:0]          len_o
);
  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] ext_cycles;

  always_comb begin
    base       = (mode_i == acq_window_pkg::ACQ_MODE_HI) ? CNT_W'(HI_BASE) : CNT_W'(LO_BASE);
    // extension counts in pairs of cycles
    ext_cycles = CNT_W'(ext_i) << 1;
    len_o      = base + ext_cycles;
  end
endmodule

// File: rtl/acq_down_counter.sv
module acq_down_counter #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             active_o,
  output logic             done_o
);
  logic [CNT_W-1:0] remain_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      remain_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= (remain_q == CNT_W'(1));
      if (load_i)               remain_q <= len_i;
      else if (remain_q != '0)  remain_q <= remain_q - CNT_W'(1);
    end
  end

  assign active_o = (remain_q != '0);
  assign done_o   = done_q;
endmodule

// File: rtl/acq_window_timer.sv
module acq_window_timer #(
  parameter int unsigned EXT_W   = acq_window_pkg::ACQ_EXT_W,
  parameter int unsigned HI_BASE = acq_window_pkg::ACQ_HI_BASE,
  parameter int unsigned LO_BASE = acq_window_pkg::ACQ_LO_BASE
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             mode_hi_i,
  input  logic [EXT_W-1:0] acq_ext_i,
  output logic             acq_active_o,
  output logic             done_o
);
  localparam int unsigned MAX_LEN =
    ((HI_BASE > LO_BASE) ? HI_BASE : LO_BASE) + 2 * ((1 << EXT_W) - 1);
  localparam int unsigned CNT_W = $clog2(MAX_LEN + 1);

  acq_window_pkg::acq_mode_e mode;
  logic [CNT_W-1:0]          len;
  logic                      active;
  logic                      load;

  assign mode = mode_hi_i ? acq_window_pkg::ACQ_MODE_HI : acq_window_pkg::ACQ_MODE_LO;

  acq_len_calc #(
    .EXT_W  (EXT_W),
    .CNT_W  (CNT_W),
    .HI_BASE(HI_BASE),
    .LO_BASE(LO_BASE)
  ) len_i (
    .mode_i(mode),
    .ext_i (acq_ext_i),
    .len_o (len)
  );

  // starts are accepted only while idle; the length is captured into the counter
  assign load = start_i && !active;

  acq_down_counter #(
    .CNT_W(CNT_W)
  ) cnt_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .len_i   (len),
    .active_o(active),
    .done_o  (done_o)
  );

  assign acq_active_o = active;
endmodule

// File: rtl/acq_window_timer_chk.sv
module acq_window_timer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic acq_active_o,
  input logic done_o
);
  a_r4_start_opens: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !acq_active_o) |=> acq_active_o);

  a_r4_rise_needs_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(acq_active_o) |-> $past(start_i));

  a_r5_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r5_done_after_close: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!acq_active_o && $past(acq_active_o)));

  a_r2_min_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(acq_active_o) |=> acq_active_o);

  a_r7_busy_start_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && acq_active_o) |=> (acq_active_o || done_o));
endmodule

bind acq_window_timer acq_window_timer_chk chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .acq_active_o(acq_active_o),
  .done_o      (done_o)
);

// File: tb/acq_window_timer_tb_top.sv
`timescale 1ns/1ps
module acq_window_timer_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic       mode_hi_i = 1'b0;
  logic [3:0] acq_ext_i = 4'd0;
  logic       acq_active_o;
  logic       done_o;

  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;

  acq_window_timer dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .mode_hi_i   (mode_hi_i),
    .acq_ext_i   (acq_ext_i),
    .acq_active_o(acq_active_o),
    .done_o      (done_o)
  );

  function automatic int exp_len(input logic hi, input logic [3:0] d);
    return (hi ? 9 : 2) + 2 * int'(d);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a negedge; drives the start pulse for one edge
  task automatic open_window(input logic hi, input logic [3:0] d, input bit scramble);
    start_i   = 1'b1;
    mode_hi_i = hi;
    acq_ext_i = d;
    @(negedge clk_i);
    start_i = 1'b0;
    if (scramble) begin
      mode_hi_i = ~hi;
      acq_ext_i = 4'($urandom_range(0, 15));
    end
  endtask

  // called at the first negedge after the start edge; returns at the done negedge
  task automatic measure(input int exp, input string req, input bit inject);
    int n = 0;
    check("R4 active after start", int'(acq_active_o), 1);
    while (acq_active_o && n < 100) begin
      n++;
      start_i = inject && ($urandom_range(0, 2) == 0);
      if (inject && start_i) acq_ext_i = 4'($urandom_range(0, 15));
      @(negedge clk_i);
      start_i = 1'b0;
    end
    check(req, n, exp);
    check("R5 done after close", int'(done_o), 1);
  endtask

  task automatic finish_window();
    @(negedge clk_i);
    check("R5 done single", int'(done_o), 0);
    check("R5 idle after done", int'(acq_active_o), 0);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0a1c));
    // R8 reset state, start ignored under reset
    start_i = 1'b1;
    repeat (3) @(negedge clk_i);
    check("R8 reset active", int'(acq_active_o), 0);
    check("R8 reset done", int'(done_o), 0);
    start_i = 1'b0;
    rst_ni  = 1'b1;
    @(negedge clk_i);
    check("R8 idle after reset", int'(acq_active_o), 0);

    // R3 extremes, R1/R2 bare base
    open_window(1'b1, 4'd0, 1'b0);  measure(9,  "R1 hi D=0 R3", 1'b0); finish_window();
    open_window(1'b0, 4'd0, 1'b0);  measure(2,  "R2 lo D=0 R3", 1'b0); finish_window();
    open_window(1'b1, 4'd15, 1'b0); measure(39, "R1 hi D=15 R3", 1'b0); finish_window();
    open_window(1'b0, 4'd15, 1'b0); measure(32, "R2 lo D=15 R3", 1'b0); finish_window();

    // R6 inputs changed mid-window
    open_window(1'b0, 4'd3, 1'b1);  measure(8,  "R6 captured lo", 1'b0); finish_window();
    open_window(1'b1, 4'd5, 1'b1);  measure(19, "R6 captured hi", 1'b0); finish_window();

    // R7 start on the final active cycle is dropped
    open_window(1'b0, 4'd0, 1'b0);
    check("R4 active after start", int'(acq_active_o), 1);
    @(negedge clk_i);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    check("R7 last-cycle start dropped", int'(acq_active_o), 0);
    check("R5 done after close", int'(done_o), 1);
    finish_window();

    // R9 back-to-back from the done cycle
    open_window(1'b1, 4'd2, 1'b0); measure(13, "R1 first window", 1'b0);
    open_window(1'b0, 4'd4, 1'b0); measure(10, "R9 back-to-back", 1'b0);
    open_window(1'b0, 4'd0, 1'b0); measure(2,  "R9 back-to-back min", 1'b0);
    finish_window();

    // R8 reset mid-window
    open_window(1'b1, 4'd7, 1'b0);
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check("R8 reset ends window", int'(acq_active_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (30) begin
      @(negedge clk_i);
      if (done_o) check("R8 no done after reset", 1, 0);
    end
    check("R8 quiet after reset", int'(acq_active_o) + int'(done_o), 0);

    // random windows with busy starts (R7) and scrambled inputs (R6)
    for (int i = 0; i < 60; i++) begin
      logic       hi = 1'($urandom_range(0, 1));
      logic [3:0] d  = 4'($urandom_range(0, 15));
      open_window(hi, d, 1'b1);
      measure(exp_len(hi, d), hi ? "R1 R7 random" : "R2 R7 random", 1'b1);
      if ($urandom_range(0, 3) != 0) finish_window();
      else begin
        hi = 1'($urandom_range(0, 1));
        d  = 4'($urandom_range(0, 15));
        open_window(hi, d, 1'b0);
        measure(exp_len(hi, d), "R9 random back-to-back", 1'b0);
        finish_window();
      end
      repeat ($urandom_range(0, 3)) @(negedge clk_i);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule